// File: doc/BRIEF.md
# Ping-Pong DMA Descriptor Sequencer

This block drives one DMA channel that owns two descriptor banks. Each bank holds a source address, a destination address and a length word; bit 31 of the length word arms the bank and the low bits give the word count. Software loads the banks through a single-cycle register write port and can read every register, plus a control/status word, through a combinational read port. The block issues a launch to a transfer engine as a one-cycle start pulse, together with held copies of the bank's addresses and count. It then waits for the engine's one-cycle completion pulse.

When a transfer finishes, the sequencer disarms the bank it just ran and sets a sticky completion flag. If the opposite bank is armed, it launches that bank at once. Software can therefore refill whichever bank is idle while the other runs, and the channel keeps swapping banks until neither is armed. Register map, with `wr_addr`/`rd_addr` bit 2 selecting the bank: 0/4 source, 1/5 destination, 2/6 length, 3 control/status, 7 reads zero.

Top module: `dma_pingpong_seq`

## Requirements
- R1: After reset, every register reads 0 and `xfer_start` is 0.
- R2: In a length register, bit 31 is the arm bit and bits CW-1:0 are the word count, and both read back as written. Writing a length word with bit 31 clear starts nothing.
- R3: Writing a length word with bit 31 set while the channel is idle produces a one-cycle `xfer_start`. This pulse appears in the second clock after the write is sampled, with `xfer_src`, `xfer_dst` and `xfer_len` equal to that bank's registers.
- R4: A `xfer_done` pulse while busy clears the arm bit of the running bank (its count is kept) and sets the completion flag, control bit 0.
- R5: If the opposite bank is armed when the running transfer finishes, `xfer_start` for that bank follows in the next cycle and the channel stays busy. Software may load the idle bank while the other bank runs.
- R6: If the opposite bank is not armed when the running transfer finishes, the channel goes idle and issues no further start.
- R7: Writes to the running bank's registers do not change `xfer_src`, `xfer_dst` or `xfer_len` during that transfer.
- R8: Writing control with bit 0 set clears the completion flag, and writing bit 0 as 0 leaves it unchanged. A finish in the same cycle as a clear leaves the flag set.
- R9: A `xfer_done` pulse while idle has no effect: the flag stays as it was and nothing starts.
- R10: Control bit 1 reads as busy, and control bit 2 reads as the index of the bank that was launched last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 32 | Register read data (combinational) |
| xfer_start | output | 1 | One-cycle launch pulse to the engine |
| xfer_src | output | AW | Source address of the running transfer |
| xfer_dst | output | AW | Destination address of the running transfer |
| xfer_len | output | CW | Word count of the running transfer |
| xfer_done | input | 1 | One-cycle completion pulse from the engine |

## Verification
The bench targets the hand-over between banks. A design that reads the wrong arm bit there would either stall after the first bank or restart the bank that just finished. It rewrites the running bank in mid-transfer; a design that fed the engine straight from the registers would then show the new address on `xfer_src`. It also clears the flag in the same cycle as a finish, which a design that gave the clear priority would lose, and it pulses `xfer_done` while idle, which a design without a busy guard would report as a spurious completion.

// File: rtl/dps_pkg.sv
package dps_pkg;
  // Field selector held in address bits 1:0.
  localparam logic [1:0] F_SRC = 2'd0;
  localparam logic [1:0] F_DST = 2'd1;
  localparam logic [1:0] F_LEN = 2'd2;
  localparam logic [1:0] F_CTL = 2'd3;
  localparam logic [2:0] CTL_ADDR = 3'd3;
  // Bit positions.
  localparam int ARM_BIT  = 31;
  localparam int CTL_DONE = 0;
  localparam int CTL_BUSY = 1;
  localparam int CTL_ACT  = 2;
endpackage

// File: rtl/dps_bank.sv
module dps_bank #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_src,
  input  logic          ld_dst,
  input  logic          ld_len,
  input  logic [AW-1:0] wd_addr,
  input  logic [CW-1:0] wd_cnt,
  input  logic          wd_arm,
  input  logic          clr_arm,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          arm
);
  logic [AW-1:0] src_d, dst_d;
  logic [CW-1:0] cnt_d;
  logic          arm_d;

  always_comb begin
    src_d = ld_src ? wd_addr : src;
    dst_d = ld_dst ? wd_addr : dst;
    cnt_d = ld_len ? wd_cnt  : cnt;
    // The hardware disarm wins over a software write in the same cycle.
    if (clr_arm)     arm_d = 1'b0;
    else if (ld_len) arm_d = wd_arm;
    else             arm_d = arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
      arm <= 1'b0;
    end else begin
      src <= src_d;
      dst <= dst_d;
      cnt <= cnt_d;
      arm <= arm_d;
    end
  end
endmodule

// File: rtl/dps_seq.sv
module dps_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bank_arm,
  input  logic [1:0][AW-1:0]  bank_src,
  input  logic [1:0][AW-1:0]  bank_dst,
  input  logic [1:0][CW-1:0]  bank_cnt,
  input  logic                xfer_done,
  input  logic                flag_clr,
  output logic [1:0]          clr_arm,
  output logic                busy,
  output logic                act,
  output logic                done_flag,
  output logic                xfer_start,
  output logic [AW-1:0]       xfer_src,
  output logic [AW-1:0]       xfer_dst,
  output logic [CW-1:0]       xfer_len
);
  logic launch, pick, fin;
  logic busy_d, act_d, flag_d;

  always_comb begin
    fin    = busy & xfer_done;
    launch = 1'b0;
    pick   = act;
    if (!busy) begin
      if (bank_arm[0]) begin
        launch = 1'b1;
        pick   = 1'b0;
      end else if (bank_arm[1]) begin
        launch = 1'b1;
        pick   = 1'b1;
      end
    end else if (fin && bank_arm[!act]) begin
      launch = 1'b1;
      pick   = !act;
    end
    busy_d  = launch | (busy & ~xfer_done);
    act_d   = launch ? pick : act;
    flag_d  = fin | (done_flag & ~flag_clr);
    clr_arm = fin ? (act ? 2'b10 : 2'b01) : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      act        <= 1'b0;
      done_flag  <= 1'b0;
      xfer_start <= 1'b0;
      xfer_src   <= '0;
      xfer_dst   <= '0;
      xfer_len   <= '0;
    end else begin
      busy       <= busy_d;
      act        <= act_d;
      done_flag  <= flag_d;
      xfer_start <= launch;
      if (launch) begin
        xfer_src <= bank_src[pick];
        xfer_dst <= bank_dst[pick];
        xfer_len <= bank_cnt[pick];
      end
    end
  end
endmodule

// File: rtl/dma_pingpong_seq.sv
module dma_pingpong_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          xfer_start,
  output logic [AW-1:0] xfer_src,
  output logic [AW-1:0] xfer_dst,
  output logic [CW-1:0] xfer_len,
  input  logic          xfer_done
);
  import dps_pkg::*;

  localparam int NBANK = 2;

  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  logic [NBANK-1:0]         bank_arm, clr_arm;
  logic [NBANK-1:0][AW-1:0] b_src, b_dst;
  logic [NBANK-1:0][CW-1:0] b_cnt;
  logic busy, act, done_flag, flag_clr;

  assign flag_clr = wr_en && (wr_addr == CTL_ADDR) && wr_data[CTL_DONE];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (wr_addr[2] == 1'(b));
    dps_bank #(.AW(AW), .CW(CW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .ld_src  (hit && wr_addr[1:0] == F_SRC),
      .ld_dst  (hit && wr_addr[1:0] == F_DST),
      .ld_len  (hit && wr_addr[1:0] == F_LEN),
      .wd_addr (wr_data[AW-1:0]),
      .wd_cnt  (wr_data[CW-1:0]),
      .wd_arm  (wr_data[ARM_BIT]),
      .clr_arm (clr_arm[b]),
      .src     (b_src[b]),
      .dst     (b_dst[b]),
      .cnt     (b_cnt[b]),
      .arm     (bank_arm[b])
    );
  end

  dps_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .bank_arm   (bank_arm),
    .bank_src   (b_src),
    .bank_dst   (b_dst),
    .bank_cnt   (b_cnt),
    .xfer_done  (xfer_done),
    .flag_clr   (flag_clr),
    .clr_arm    (clr_arm),
    .busy       (busy),
    .act        (act),
    .done_flag  (done_flag),
    .xfer_start (xfer_start),
    .xfer_src   (xfer_src),
    .xfer_dst   (xfer_dst),
    .xfer_len   (xfer_len)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTL_ADDR) begin
      rd_data[CTL_DONE] = done_flag;
      rd_data[CTL_BUSY] = busy;
      rd_data[CTL_ACT]  = act;
    end else begin
      case (rd_addr[1:0])
        F_SRC: rd_data[AW-1:0] = b_src[rd_addr[2]];
        F_DST: rd_data[AW-1:0] = b_dst[rd_addr[2]];
        F_LEN: begin
          rd_data[CW-1:0]  = b_cnt[rd_addr[2]];
          rd_data[ARM_BIT] = bank_arm[rd_addr[2]];
        end
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          act,
  input logic          done_flag,
  input logic [1:0]    bank_arm,
  input logic          xfer_start,
  input logic          xfer_done,
  input logic [AW-1:0] xfer_src,
  input logic [AW-1:0] xfer_dst,
  input logic [CW-1:0] xfer_len
);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> busy);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_start) |-> ($stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_len)));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done) |=> done_flag);

  p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done) |=> !bank_arm[$past(act)]);

  p_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && bank_arm[!act]) |=> (xfer_start && busy && (act != $past(act))));

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && !bank_arm[!act]) |=> !busy);

  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xfer_done && !done_flag) |=> !done_flag);
endmodule

bind dma_pingpong_seq dps_checker #(.AW(AW), .CW(CW)) u_dps_checker (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .busy       (busy),
  .act        (act),
  .done_flag  (done_flag),
  .bank_arm   (bank_arm),
  .xfer_start (xfer_start),
  .xfer_done  (xfer_done),
  .xfer_src   (xfer_src),
  .xfer_dst   (xfer_dst),
  .xfer_len   (xfer_len)
);

// File: tb/test_dma_pingpong_seq.sv
module test_dma_pingpong_seq;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          xfer_start;
  logic [AW-1:0] xfer_src, xfer_dst;
  logic [CW-1:0] xfer_len;
  logic          xfer_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_pingpong_seq #(.AW(AW), .CW(CW)) i_dma_pingpong_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .xfer_start(xfer_start), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_len(xfer_len), .xfer_done(xfer_done)
  );

  typedef struct packed {
    logic        bk;
    logic [31:0] s;
    logic [31:0] d;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 32'h0000_4000, 32'hFC00_0004, 16'd16},
    '{1'b1, 32'h0000_4F00, 32'hA200_0004, 16'd6},
    '{1'b0, 32'h0000_4A00, 32'h1000_0004, 16'd1},
    '{1'b1, 32'hFFFF_FFFC, 32'h0000_0000, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset start", {31'h0, xfer_start}, 32'h0);

    // Vector table: single-bank runs from idle
    for (int i = 0; i < 4; i++) begin
      logic [2:0] base;
      base = {VECS[i].bk, 2'b00};
      wr(base | 3'd0, VECS[i].s);
      wr(base | 3'd1, VECS[i].d);
      wr(base | 3'd2, {16'h0, VECS[i].n});
      @(negedge clk);
      chk("R2 unarmed no start", {31'h0, xfer_start}, 32'h0);
      rd(base | 3'd2, d);
      chk("R2 length readback", d, {16'h0, VECS[i].n});
      wr(base | 3'd2, 32'h8000_0000 | {16'h0, VECS[i].n});
      rd(base | 3'd2, d);
      chk("R2 armed readback", d, 32'h8000_0000 | {16'h0, VECS[i].n});
      @(negedge clk);
      chk("R3 start", {31'h0, xfer_start}, 32'h1);
      chk("R3 src", xfer_src, VECS[i].s);
      chk("R3 dst", xfer_dst, VECS[i].d);
      chk("R3 len", {16'h0, xfer_len}, {16'h0, VECS[i].n});
      rd(3'd3, d);
      chk("R10 status busy/act", d, {29'h0, VECS[i].bk, 2'b10});
      @(negedge clk);
      chk("R3 single pulse", {31'h0, xfer_start}, 32'h0);
      pulse_done();
      rd(3'd3, d);
      chk("R4 flag set, R6 idle", d, {29'h0, VECS[i].bk, 2'b01});
      rd(base | 3'd2, d);
      chk("R4 arm cleared", d, {16'h0, VECS[i].n});
      @(negedge clk);
      chk("R6 no restart", {31'h0, xfer_start}, 32'h0);
      wr(3'd3, 32'h1);
      rd(3'd3, d);
      chk("R8 flag cleared", d & 32'h1, 32'h0);
    end

    // R5 / R7: chained run with the idle bank loaded mid-transfer
    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'h2000_0000);
    wr(3'd2, 32'h8000_0008);
    @(negedge clk);
    chk("R3 chain first start", {31'h0, xfer_start}, 32'h1);
    wr(3'd4, 32'h0000_5000);
    wr(3'd5, 32'h3000_0000);
    wr(3'd6, 32'h8000_0004);
    wr(3'd0, 32'hDEAD_0000);
    wr(3'd2, 32'h0000_0077);
    chk("R7 src held", xfer_src, 32'h0000_1000);
    chk("R7 len held", {16'h0, xfer_len}, 32'h8);
    chk("R5 no start while busy", {31'h0, xfer_start}, 32'h0);
    pulse_done();
    chk("R5 chained start", {31'h0, xfer_start}, 32'h1);
    chk("R5 chained src", xfer_src, 32'h0000_5000);
    chk("R5 chained len", {16'h0, xfer_len}, 32'h4);
    rd(3'd3, d);
    chk("R10 status bank 1", d, 32'h7);
    @(negedge clk);
    chk("R5 chained single pulse", {31'h0, xfer_start}, 32'h0);
    pulse_done();
    rd(3'd3, d);
    chk("R6 idle after both", d, 32'h5);
    repeat (2) @(negedge clk);
    chk("R6 stays idle", {31'h0, xfer_start}, 32'h0);

    // R8: write 0 keeps flag, write 1 clears
    wr(3'd3, 32'h0);
    rd(3'd3, d);
    chk("R8 write zero keeps flag", d & 32'h1, 32'h1);
    wr(3'd3, 32'h1);
    rd(3'd3, d);
    chk("R8 clear", d & 32'h1, 32'h0);

    // R9: done while idle ignored
    pulse_done();
    rd(3'd3, d);
    chk("R9 idle done flag", d, 32'h4);
    chk("R9 idle done start", {31'h0, xfer_start}, 32'h0);

    // R8: finish and clear in the same cycle, set wins
    wr(3'd2, 32'h8000_0002);
    @(negedge clk);
    chk("R3 restart", {31'h0, xfer_start}, 32'h1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h1; xfer_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; xfer_done = 1'b0;
    rd(3'd3, d);
    chk("R8 set beats clear", d & 32'h1, 32'h1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule